// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is the arithmetic and logic unit that sits beside the accumulator of a small byte-wide microcontroller core. Each clock it takes an operation code, the current accumulator value, a source byte and the current carry flag. It forms an 8-bit result and the three status flags that the operation defines: carry, half carry and signed overflow. It supports addition with and without the incoming carry, and subtraction with borrow. It also supports bitwise AND, OR and XOR, clearing and complementing the accumulator, rotates with or without the carry, and a nibble exchange.

The datapath itself is combinational. The result, the flag values and the per-flag update strobes are captured in one register stage. The core's status register writes a flag only when that flag's strobe is high, so an operation never disturbs a flag it does not define. Addressing of the source operand, decimal adjust, multiply and divide belong to other blocks.

Top module: `acc_alu`

## Requirements
- R1: A synchronous active-high reset drives the result, all three flag values and all three update strobes to zero at the next rising edge.
- R2: Outputs change only at a rising clock edge. They show the operation whose inputs were present at the previous rising edge, so the latency is one cycle.
- R3: Code 0 (add) gives (acc + src) mod 256. Carry is the carry out of bit 7, half carry is the carry out of bit 3, and overflow is the carry out of bit 6 XOR the carry out of bit 7. All three strobes are high. For example, C3h + AAh gives 6Dh with carry 1, overflow 1 and half carry 0.
- R4: Code 1 (add with carry) works as R3 with the incoming carry added as well. C3h + AAh with carry-in 1 gives 6Eh with carry 1, overflow 1 and half carry 0.
- R5: Code 2 (subtract with borrow) gives (acc − src − carry-in) mod 256. Carry is the borrow out of bit 7, half carry is the borrow out of bit 3, and overflow is set on signed overflow of the subtraction. All three strobes are high.
- R6: Codes 3, 4 and 5 give acc AND src, acc OR src and acc XOR src. All three update strobes are low. A flag whose strobe is low is driven 0.
- R7: Code 6 gives 00h and code 7 gives the bitwise complement of acc. Neither raises a strobe.
- R8: Code 8 rotates acc left by one bit (bit 7 into bit 0) and code 10 rotates it right by one bit (bit 0 into bit 7). Neither raises a strobe.
- R9: Code 9 shifts acc left with the incoming carry entering bit 0, and the new carry is the old bit 7. Code 11 shifts right with the carry entering bit 7, and the new carry is the old bit 0. Only the carry strobe is high.
- R10: Code 12 exchanges the upper and lower nibbles of acc and raises no strobe.
- R11: Codes 13 to 15 are unassigned. They pass acc to the result unchanged and raise no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_i | input | 4 | Operation code |
| acc_i | input | 8 | Accumulator operand |
| src_i | input | 8 | Source operand |
| cy_i | input | 1 | Incoming carry flag |
| res_o | output | 8 | Registered result byte |
| cy_o | output | 1 | Carry flag value |
| ac_o | output | 1 | Half-carry flag value |
| ov_o | output | 1 | Overflow flag value |
| cy_we_o | output | 1 | Carry update strobe |
| ac_we_o | output | 1 | Half-carry update strobe |
| ov_we_o | output | 1 | Overflow update strobe |

## Verification
The assertions assume that the operation code, both operand bytes and the carry input are known values at every rising edge outside reset. They also assume that reset is sampled only at a clock edge, because the one-cycle look-back they use relates a result to the operands captured in the previous cycle. The stimulus drives every input at the falling edge from fully defined values. It holds reset for whole cycles only, and it applies unassigned operation codes only as ordinary known values, so every clocked check compares defined data.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

    localparam int DATA_W = 8;
    localparam int OP_W   = 4;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 4'd0,
        OP_ADDC = 4'd1,
        OP_SUBB = 4'd2,
        OP_AND  = 4'd3,
        OP_OR   = 4'd4,
        OP_XOR  = 4'd5,
        OP_CLR  = 4'd6,
        OP_CPL  = 4'd7,
        OP_RL   = 4'd8,
        OP_RLC  = 4'd9,
        OP_RR   = 4'd10,
        OP_RRC  = 4'd11,
        OP_SWAP = 4'd12
    } alu_op_e;

    typedef struct packed {
        logic c;
        logic ac;
        logic ov;
    } flags_t;

    // Which flags an operation is allowed to update
    function automatic flags_t flag_mask(alu_op_e op);
        flags_t m;
        m = '0;
        case (op)
            OP_ADD, OP_ADDC, OP_SUBB: m = '{c: 1'b1, ac: 1'b1, ov: 1'b1};
            OP_RLC, OP_RRC:           m = '{c: 1'b1, ac: 1'b0, ov: 1'b0};
            default:                  m = '0;
        endcase
        return m;
    endfunction

    function automatic logic is_arith(alu_op_e op);
        return (op == OP_ADD) || (op == OP_ADDC) || (op == OP_SUBB);
    endfunction

endpackage

// File: rtl/acc_alu_arith.sv
module acc_alu_arith
    import acc_alu_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         ci_i,
    input  logic         sub_i,
    output logic [W-1:0] sum_o,
    output flags_t       fl_o
);
    localparam int H = W / 2;

    logic [W:0]   full;
    logic [H:0]   low;
    logic [W-1:0] below_msb;

    always_comb begin
        if (sub_i) begin
            full      = {1'b0, a_i} - {1'b0, b_i} - {{W{1'b0}}, ci_i};
            low       = {1'b0, a_i[H-1:0]} - {1'b0, b_i[H-1:0]} - {{H{1'b0}}, ci_i};
            below_msb = {1'b0, a_i[W-2:0]} - {1'b0, b_i[W-2:0]} - {{(W-1){1'b0}}, ci_i};
        end else begin
            full      = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, ci_i};
            low       = {1'b0, a_i[H-1:0]} + {1'b0, b_i[H-1:0]} + {{H{1'b0}}, ci_i};
            below_msb = {1'b0, a_i[W-2:0]} + {1'b0, b_i[W-2:0]} + {{(W-1){1'b0}}, ci_i};
        end
        sum_o    = full[W-1:0];
        fl_o.c   = full[W];
        fl_o.ac  = low[H];
        fl_o.ov  = full[W] ^ below_msb[W-1];
    end

    always_comb begin
        // R5
        if (sub_i && (b_i == '0) && !ci_i) begin
            sub_noborrow_chk: assert (!fl_o.c && !fl_o.ov);
        end
    end

endmodule

// File: rtl/acc_alu_bitops.sv
module acc_alu_bitops
    import acc_alu_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  alu_op_e      op_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         ci_i,
    output logic [W-1:0] res_o,
    output logic         co_o
);
    localparam int H = W / 2;

    always_comb begin
        res_o = a_i;
        co_o  = ci_i;
        case (op_i)
            OP_AND:  res_o = a_i & b_i;
            OP_OR:   res_o = a_i | b_i;
            OP_XOR:  res_o = a_i ^ b_i;
            OP_CLR:  res_o = '0;
            OP_CPL:  res_o = ~a_i;
            OP_RL:   res_o = {a_i[W-2:0], a_i[W-1]};
            OP_RR:   res_o = {a_i[0], a_i[W-1:1]};
            OP_RLC: begin
                res_o = {a_i[W-2:0], ci_i};
                co_o  = a_i[W-1];
            end
            OP_RRC: begin
                res_o = {ci_i, a_i[W-1:1]};
                co_o  = a_i[0];
            end
            OP_SWAP: res_o = {a_i[H-1:0], a_i[W-1:H]};
            default: res_o = a_i;
        endcase
    end

endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_alu_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [OP_W-1:0] op_i,
    input  logic [W-1:0]   acc_i,
    input  logic [W-1:0]   src_i,
    input  logic           cy_i,
    output logic [W-1:0]   res_o,
    output logic           cy_o,
    output logic           ac_o,
    output logic           ov_o,
    output logic           cy_we_o,
    output logic           ac_we_o,
    output logic           ov_we_o
);
    localparam int H = W / 2;

    alu_op_e      op_e;
    logic         arith_sel;
    logic         arith_ci;
    logic [W-1:0] arith_res;
    flags_t       arith_fl;
    logic [W-1:0] bit_res;
    logic         bit_co;
    flags_t       mask_d;
    flags_t       raw_fl;
    logic [W-1:0] res_d;

    logic [W-1:0] res_q;
    flags_t       val_q;
    flags_t       upd_q;

    assign op_e      = alu_op_e'(op_i);
    assign arith_sel = is_arith(op_e);
    assign arith_ci  = (op_e == OP_ADD) ? 1'b0 : cy_i;
    assign mask_d    = flag_mask(op_e);

    acc_alu_arith #(.W(W)) u_arith (
        .a_i   (acc_i),
        .b_i   (src_i),
        .ci_i  (arith_ci),
        .sub_i (op_e == OP_SUBB),
        .sum_o (arith_res),
        .fl_o  (arith_fl)
    );

    acc_alu_bitops #(.W(W)) u_bitops (
        .op_i  (op_e),
        .a_i   (acc_i),
        .b_i   (src_i),
        .ci_i  (cy_i),
        .res_o (bit_res),
        .co_o  (bit_co)
    );

    always_comb begin
        if (arith_sel) begin
            res_d  = arith_res;
            raw_fl = arith_fl;
        end else begin
            res_d  = bit_res;
            raw_fl = '{c: bit_co, ac: 1'b0, ov: 1'b0};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
            val_q <= '0;
            upd_q <= '0;
        end else begin
            res_q <= res_d;
            val_q <= flags_t'(raw_fl & mask_d);
            upd_q <= mask_d;
        end
    end

    assign res_o   = res_q;
    assign cy_o    = val_q.c;
    assign ac_o    = val_q.ac;
    assign ov_o    = val_q.ov;
    assign cy_we_o = upd_q.c;
    assign ac_we_o = upd_q.ac;
    assign ov_we_o = upd_q.ov;

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (res_o == '0 && upd_q == '0 && val_q == '0));

    // R3
    add_sum_chk: assert property (@(posedge clk) disable iff (rst)
        (op_i == 4'd0) |=> ({cy_o, res_o} == ({1'b0, $past(acc_i)} + {1'b0, $past(src_i)})));

    // R6
    logic_noflag_chk: assert property (@(posedge clk) disable iff (rst)
        (op_i inside {4'd3, 4'd4, 4'd5}) |=> (!cy_we_o && !ac_we_o && !ov_we_o));

    // R9
    rlc_carry_chk: assert property (@(posedge clk) disable iff (rst)
        (op_i == 4'd9) |=> (cy_we_o && !ac_we_o && !ov_we_o
                            && cy_o == $past(acc_i[W-1]) && res_o[0] == $past(cy_i)));

    // R10
    swap_nib_chk: assert property (@(posedge clk) disable iff (rst)
        (op_i == 4'd12) |=> (res_o == {$past(acc_i[H-1:0]), $past(acc_i[W-1:H])}));

    // R11
    undef_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (op_i >= 4'd13) |=> (res_o == $past(acc_i) && upd_q == '0));

endmodule

// File: tb/acc_alu_bench.sv
`timescale 1ns/1ps
module acc_alu_bench;

    logic       clk = 1'b0;
    logic       rst;
    logic [3:0] op;
    logic [7:0] acc, src;
    logic       cy;
    logic [7:0] res;
    logic       cy_o, ac_o, ov_o, cy_we, ac_we, ov_we;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    acc_alu u_acc_alu (
        .clk(clk), .rst(rst), .op_i(op), .acc_i(acc), .src_i(src), .cy_i(cy),
        .res_o(res), .cy_o(cy_o), .ac_o(ac_o), .ov_o(ov_o),
        .cy_we_o(cy_we), .ac_we_o(ac_we), .ov_we_o(ov_we)
    );

    function automatic string req_of(int o);
        case (o)
            0: return "R3";
            1: return "R4";
            2: return "R5";
            3, 4, 5: return "R6";
            6, 7: return "R7";
            8, 10: return "R8";
            9, 11: return "R9";
            12: return "R10";
            default: return "R11";
        endcase
    endfunction

    // Behavioural reference: returns {res[7:0], c, ac, ov, we_c, we_ac, we_ov}
    function automatic logic [13:0] model(int o, int a, int b, int ci);
        int r, c, h, v, wc, wh, wv, t, s6;
        r = a; c = 0; h = 0; v = 0; wc = 0; wh = 0; wv = 0;
        case (o)
            0, 1: begin
                t  = (o == 1) ? ci : 0;
                r  = (a + b + t) % 256;
                c  = (a + b + t) > 255;
                h  = ((a % 16) + (b % 16) + t) > 15;
                s6 = ((a % 128) + (b % 128) + t) > 127;
                v  = c ^ s6;
                wc = 1; wh = 1; wv = 1;
            end
            2: begin
                t  = a - b - ci;
                r  = (t + 512) % 256;
                c  = t < 0;
                h  = ((a % 16) - (b % 16) - ci) < 0;
                s6 = ((a % 128) - (b % 128) - ci) < 0;
                v  = c ^ s6;
                wc = 1; wh = 1; wv = 1;
            end
            3: r = a & b;
            4: r = a | b;
            5: r = a ^ b;
            6: r = 0;
            7: r = 255 - a;
            8: r = ((a * 2) % 256) + (a / 128);
            9: begin r = ((a * 2) % 256) + ci; c = a / 128; wc = 1; end
            10: r = (a / 2) + (a % 2) * 128;
            11: begin r = (a / 2) + ci * 128; c = a % 2; wc = 1; end
            12: r = (a % 16) * 16 + (a / 16);
            default: r = a;
        endcase
        return {r[7:0], c[0], h[0], v[0], wc[0], wh[0], wv[0]};
    endfunction

    function automatic logic [13:0] observed();
        return {res, cy_o, ac_o, ov_o, cy_we, ac_we, ov_we};
    endfunction

    task automatic compare(string tag, logic [13:0] got, logic [13:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s actual res=%02h c/ac/ov=%b we=%b expected res=%02h c/ac/ov=%b we=%b",
                     tag, got[13:6], got[5:3], got[2:0], exp[13:6], exp[5:3], exp[2:0]);
        end
    endtask

    // Called just after a falling edge; result seen after the next rising edge (R2)
    task automatic apply(int o, int a, int b, int ci);
        op = 4'(o); acc = 8'(a); src = 8'(b); cy = 1'(ci);
        @(posedge clk);
        @(negedge clk);
        compare($sformatf("%s op=%0d a=%02h b=%02h ci=%0d", req_of(o), o, a, b, ci),
                observed(), model(o, a, b, ci));
    endtask

    initial begin
        int corner[6] = '{8'h00, 8'h0F, 8'h10, 8'h7F, 8'h80, 8'hFF};
        logic [13:0] held;
        rst = 1'b1; op = '0; acc = 8'h5A; src = 8'hA5; cy = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        compare("R1 reset", observed(), 14'h0);
        rst = 1'b0;

        // Directed cases from the requirements
        apply(0, 8'hC3, 8'hAA, 0);   // R3: 6D, C=1 OV=1 AC=0
        compare("R3 example", observed(), {8'h6D, 3'b101, 3'b111});
        apply(1, 8'hC3, 8'hAA, 1);   // R4: 6E, C=1 OV=1 AC=0
        compare("R4 example", observed(), {8'h6E, 3'b101, 3'b111});
        apply(3, 8'hC3, 8'h55, 1);   // R6: 41
        compare("R6 example", observed(), {8'h41, 6'b0});
        apply(7, 8'h5C, 8'h00, 0);   // R7: A3
        compare("R7 example", observed(), {8'hA3, 6'b0});
        apply(2, 8'h00, 8'h01, 0);   // R5: 00-01 = FF borrow, half borrow
        compare("R5 example", observed(), {8'hFF, 3'b110, 3'b111});
        apply(2, 8'h80, 8'h01, 0);   // R5: signed overflow 7F
        compare("R5 overflow", observed(), {8'h7F, 3'b011, 3'b111});

        // R2: a change of inputs between edges does not reach the outputs
        held = observed();
        op = 4'd6; acc = 8'h33;
        #2;
        compare("R2 hold", observed(), held);
        @(negedge clk);

        // Corner operand grid for every code
        for (int o = 0; o < 16; o++)
            for (int i = 0; i < 6; i++)
                for (int j = 0; j < 6; j++)
                    for (int c = 0; c < 2; c++)
                        apply(o, corner[i], corner[j], c);

        // Random operands for every code
        for (int o = 0; o < 16; o++)
            for (int k = 0; k < 9000; k++)
                apply(o, $urandom_range(0, 255), $urandom_range(0, 255), $urandom_range(0, 1));

        // R1: reset in the middle of operation
        op = 4'd0; acc = 8'hFF; src = 8'hFF; cy = 1'b1; rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        compare("R1 mid-run reset", observed(), 14'h0);
        rst = 1'b0;
        apply(11, 8'h01, 8'h00, 1);  // R9 after reset

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (199000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule